// File: doc/BRIEF.md
# Downstream Address Trap Translator

This block sits on the path of memory requests that leave a host port and head toward the endpoints behind a managed switch. Each request address is compared at once against a small table of programmable windows ("traps"). When a window covers the address, the address is moved out of the host's own address domain and into the global domain owned by the management processor. The new address is the window's global base plus the request's offset from the window's host base. When no window covers the address, the request is rejected as unsupported and is not forwarded.

The management side writes one window each time the host assigns a BAR. It gives the window's host base, its size and its global base. A single window can span a whole contiguous group of virtual-function BARs. Software can invalidate a single window. A reset or shutdown of the host drops every window at once. A window whose size is not a nonzero power of two is refused and stays invalid. When windows overlap, the one with the smallest index is used. The result appears one clock after the request.

Top module: `addr_trap_xlat`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `out_vld` and `out_unsup` are 0, and no window is valid, so every later request misses until a window is written.
- R2: A request with `req_vld`=1 on a cycle edge hits window i when window i is valid and `(req_addr & ~(size-1)) == (host_base & ~(size-1))`. Software aligns the host base to the size. After that edge, `out_vld`=1, `out_addr` = global_base + (req_addr - host_base) modulo 2^ADDR_W, and `out_idx`=i for exactly one cycle.
- R3: For a request that hits no valid window, `out_unsup`=1 and `out_vld`=0 for exactly one cycle after that edge. Each request produces exactly one of the two results. With no request, both outputs are 0 in the following cycle.
- R4: All address fields and comparisons use the full ADDR_W (default 64) bits, so windows above 4 GiB translate correctly. An address one byte past a window's end misses that window.
- R5: When several valid windows cover an address, the window with the lowest index is used.
- R6: A write (`cfg_wr`=1) whose `cfg_size` is zero or not a power of two leaves window `cfg_idx` invalid, even if it was valid before. A write with a legal size makes that window valid with the given fields.
- R7: `cfg_inv`=1 makes window `cfg_idx` invalid and takes priority over a `cfg_wr` in the same cycle.
- R8: `host_rst`=1 invalidates all windows and takes priority over `cfg_wr` and `cfg_inv`.
- R9: A table change on a clock edge affects only requests sampled on later edges. A request sampled on the same edge sees the table as it was before the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_rst | input | 1 | Host port reset or shutdown; drops all windows |
| cfg_wr | input | 1 | Write the window at cfg_idx |
| cfg_inv | input | 1 | Invalidate the window at cfg_idx |
| cfg_idx | input | IDX_W | Window index for cfg_wr or cfg_inv |
| cfg_host_base | input | ADDR_W | Window base in the host domain |
| cfg_size | input | ADDR_W | Window size in bytes (must be a nonzero power of two) |
| cfg_glob_base | input | ADDR_W | Window base in the global domain |
| req_vld | input | 1 | Downstream memory request present |
| req_addr | input | ADDR_W | Request address in the host domain |
| out_vld | output | 1 | Request forwarded with a translated address |
| out_addr | output | ADDR_W | Translated global address |
| out_idx | output | IDX_W | Index of the window that matched |
| out_unsup | output | 1 | Request matched no window and is rejected |

## Verification
Every request result is due one clock after the edge that samples `req_vld`. The bench drives a request on a falling edge and reads `out_vld`, `out_unsup`, `out_addr` and `out_idx` on the next falling edge, which is after exactly one register stage. Table writes, invalidations and `host_rst` take effect on the edge that samples them. A request driven in that same cycle is therefore expected to see the old table (R9). Only requests driven after that edge are expected to see the new state.

// File: rtl/addr_trap_pkg.sv
package addr_trap_pkg;
   typedef enum logic [1:0] {
      RES_IDLE = 2'd0,
      RES_FWD  = 2'd1,
      RES_REJ  = 2'd2
   } trap_res_e;

   function automatic logic size_legal(input logic [127:0] sz, input int unsigned w);
      logic [127:0] m;
      m = (w >= 128) ? {128{1'b1}} : ((128'd1 << w) - 128'd1);
      return ((sz & m) != '0) && (((sz & m) & ((sz & m) - 128'd1)) == '0);
   endfunction
endpackage

// File: rtl/trap_table.sv
module trap_table #(
   parameter int ADDR_W = 64,
   parameter int N_TRAP = 8,
   localparam int IDX_W = (N_TRAP > 1) ? $clog2(N_TRAP) : 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           host_rst,
   input  logic                           cfg_wr,
   input  logic                           cfg_inv,
   input  logic [IDX_W-1:0]               cfg_idx,
   input  logic [ADDR_W-1:0]              cfg_host_base,
   input  logic [ADDR_W-1:0]              cfg_size,
   input  logic [ADDR_W-1:0]              cfg_glob_base,
   output logic [N_TRAP-1:0]              ent_vld,
   output logic [N_TRAP-1:0][ADDR_W-1:0]  ent_base,
   output logic [N_TRAP-1:0][ADDR_W-1:0]  ent_mask,
   output logic [N_TRAP-1:0][ADDR_W-1:0]  ent_gbase
);
   import addr_trap_pkg::*;

   logic size_ok;
   logic [127:0] size_wide;

   always_comb begin
      size_wide = '0;
      size_wide[ADDR_W-1:0] = cfg_size;
      size_ok = size_legal(size_wide, ADDR_W);
   end

   for (genvar i = 0; i < N_TRAP; i++) begin : g_ent
      logic sel;
      assign sel = (cfg_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_vld[i]   <= 1'b0;
            ent_base[i]  <= '0;
            ent_mask[i]  <= '0;
            ent_gbase[i] <= '0;
         end else if (host_rst) begin
            ent_vld[i] <= 1'b0;
         end else if (cfg_inv && sel) begin
            ent_vld[i] <= 1'b0;
         end else if (cfg_wr && sel) begin
            ent_vld[i]   <= size_ok;
            ent_base[i]  <= cfg_host_base;
            ent_mask[i]  <= cfg_size - ADDR_W'(1);
            ent_gbase[i] <= cfg_glob_base;
         end
      end
   end

   AST_HOST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      host_rst |=> (ent_vld == '0)) else $error("host reset left a trap valid"); // R8

   AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_inv && !host_rst) |=> !ent_vld[$past(cfg_idx)]) else $error("invalidate ignored"); // R7

   AST_BAD_SIZE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !cfg_inv && !host_rst && !size_ok) |=> !ent_vld[$past(cfg_idx)]) else $error("illegal size accepted"); // R6
endmodule

// File: rtl/trap_match.sv
module trap_match #(
   parameter int ADDR_W = 64,
   parameter int N_TRAP = 8,
   localparam int IDX_W = (N_TRAP > 1) ? $clog2(N_TRAP) : 1
) (
   input  logic [ADDR_W-1:0]              addr,
   input  logic [N_TRAP-1:0]              ent_vld,
   input  logic [N_TRAP-1:0][ADDR_W-1:0]  ent_base,
   input  logic [N_TRAP-1:0][ADDR_W-1:0]  ent_mask,
   input  logic [N_TRAP-1:0][ADDR_W-1:0]  ent_gbase,
   output logic                           hit,
   output logic [IDX_W-1:0]               hit_idx,
   output logic [ADDR_W-1:0]              xlat_addr
);
   logic [N_TRAP-1:0] hit_vec;

   for (genvar i = 0; i < N_TRAP; i++) begin : g_cmp
      assign hit_vec[i] = ent_vld[i] &&
         ((addr & ~ent_mask[i]) == (ent_base[i] & ~ent_mask[i]));
   end

   always_comb begin
      hit_idx = '0;
      for (int i = N_TRAP - 1; i >= 0; i--) begin
         if (hit_vec[i]) hit_idx = IDX_W'(i);
      end
      hit = |hit_vec;
      xlat_addr = ent_gbase[hit_idx] + (addr - ent_base[hit_idx]);
   end
endmodule

// File: rtl/addr_trap_xlat.sv
module addr_trap_xlat #(
   parameter int ADDR_W = 64,
   parameter int N_TRAP = 8,
   localparam int IDX_W = (N_TRAP > 1) ? $clog2(N_TRAP) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_rst,
   input  logic              cfg_wr,
   input  logic              cfg_inv,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [ADDR_W-1:0] cfg_host_base,
   input  logic [ADDR_W-1:0] cfg_size,
   input  logic [ADDR_W-1:0] cfg_glob_base,
   input  logic              req_vld,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              out_vld,
   output logic [ADDR_W-1:0] out_addr,
   output logic [IDX_W-1:0]  out_idx,
   output logic              out_unsup
);
   import addr_trap_pkg::*;

   if (ADDR_W < 32 || ADDR_W > 128) begin : g_bad_aw
      $error("ADDR_W must be within 32..128");
   end
   if (N_TRAP < 1 || (1 << IDX_W) != N_TRAP) begin : g_bad_n
      $error("N_TRAP must be a power of two");
   end

   logic [N_TRAP-1:0]             ent_vld;
   logic [N_TRAP-1:0][ADDR_W-1:0] ent_base;
   logic [N_TRAP-1:0][ADDR_W-1:0] ent_mask;
   logic [N_TRAP-1:0][ADDR_W-1:0] ent_gbase;
   logic                          hit;
   logic [IDX_W-1:0]              hit_idx;
   logic [ADDR_W-1:0]             xlat_addr;
   trap_res_e                     res_q;

   trap_table #(.ADDR_W(ADDR_W), .N_TRAP(N_TRAP)) u_table (
      .clk(clk), .rst_n(rst_n), .host_rst(host_rst),
      .cfg_wr(cfg_wr), .cfg_inv(cfg_inv), .cfg_idx(cfg_idx),
      .cfg_host_base(cfg_host_base), .cfg_size(cfg_size),
      .cfg_glob_base(cfg_glob_base),
      .ent_vld(ent_vld), .ent_base(ent_base),
      .ent_mask(ent_mask), .ent_gbase(ent_gbase)
   );

   trap_match #(.ADDR_W(ADDR_W), .N_TRAP(N_TRAP)) u_match (
      .addr(req_addr), .ent_vld(ent_vld), .ent_base(ent_base),
      .ent_mask(ent_mask), .ent_gbase(ent_gbase),
      .hit(hit), .hit_idx(hit_idx), .xlat_addr(xlat_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q    <= RES_IDLE;
         out_addr <= '0;
         out_idx  <= '0;
      end else begin
         if (!req_vld)  res_q <= RES_IDLE;
         else if (hit)  res_q <= RES_FWD;
         else           res_q <= RES_REJ;
         if (req_vld && hit) begin
            out_addr <= xlat_addr;
            out_idx  <= hit_idx;
         end
      end
   end

   assign out_vld   = (res_q == RES_FWD);
   assign out_unsup = (res_q == RES_REJ);

   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> (out_vld != out_unsup)) else $error("request without single result"); // R3

   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> (!out_vld && !out_unsup)) else $error("result without request"); // R3

   AST_NO_WINDOW_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && ent_vld == '0) |=> out_unsup) else $error("forward with empty table"); // R1
endmodule

// File: tb/addr_trap_xlat_bench.sv
module addr_trap_xlat_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 64;
   localparam int NT = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_rst = 1'b0;
   logic          cfg_wr = 1'b0;
   logic          cfg_inv = 1'b0;
   logic [IW-1:0] cfg_idx = '0;
   logic [AW-1:0] cfg_host_base = '0;
   logic [AW-1:0] cfg_size = '0;
   logic [AW-1:0] cfg_glob_base = '0;
   logic          req_vld = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          out_vld;
   logic [AW-1:0] out_addr;
   logic [IW-1:0] out_idx;
   logic          out_unsup;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   addr_trap_xlat #(.ADDR_W(AW), .N_TRAP(NT)) u_addr_trap_xlat (
      .clk(clk), .rst_n(rst_n), .host_rst(host_rst),
      .cfg_wr(cfg_wr), .cfg_inv(cfg_inv), .cfg_idx(cfg_idx),
      .cfg_host_base(cfg_host_base), .cfg_size(cfg_size),
      .cfg_glob_base(cfg_glob_base),
      .req_vld(req_vld), .req_addr(req_addr),
      .out_vld(out_vld), .out_addr(out_addr),
      .out_idx(out_idx), .out_unsup(out_unsup)
   );

   task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_trap(input int idx, input logic [AW-1:0] hb,
                          input logic [AW-1:0] sz, input logic [AW-1:0] gb);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_idx = IW'(idx);
      cfg_host_base = hb; cfg_size = sz; cfg_glob_base = gb;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic inv_trap(input int idx);
      @(negedge clk);
      cfg_inv = 1'b1; cfg_idx = IW'(idx);
      @(negedge clk);
      cfg_inv = 1'b0;
   endtask

   // request sampled on one edge, result read at the next falling edge
   task automatic expect_hit(input string req, input logic [AW-1:0] a,
                             input logic [AW-1:0] exp_a, input int exp_i);
      @(negedge clk);
      req_vld = 1'b1; req_addr = a;
      @(negedge clk);
      req_vld = 1'b0;
      chk({req, " vld"}, AW'(out_vld), AW'(1));
      chk({req, " unsup"}, AW'(out_unsup), AW'(0));
      chk({req, " addr"}, out_addr, exp_a);
      chk({req, " idx"}, AW'(out_idx), AW'(exp_i));
   endtask

   task automatic expect_miss(input string req, input logic [AW-1:0] a);
      @(negedge clk);
      req_vld = 1'b1; req_addr = a;
      @(negedge clk);
      req_vld = 1'b0;
      chk({req, " vld"}, AW'(out_vld), AW'(0));
      chk({req, " unsup"}, AW'(out_unsup), AW'(1));
   endtask

   task automatic t_reset;
      chk("R1 vld in reset", AW'(out_vld), AW'(0));
      chk("R1 unsup in reset", AW'(out_unsup), AW'(0));
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 vld after reset", AW'(out_vld), AW'(0));
      chk("R3 idle no result", AW'(out_unsup), AW'(0));
      expect_miss("R1 empty table", 64'h0000_0000_1000_0000);
   endtask

   task automatic t_basic;
      wr_trap(0, 64'h1000_0000, 64'h1000, 64'h8_0000_0000);
      expect_hit("R2 basic", 64'h1000_0123, 64'h8_0000_0123, 0);
      expect_miss("R3 outside", 64'h2000_0000);
   endtask

   task automatic t_wide;
      wr_trap(1, 64'hFFFF_0000_0000_0000, 64'h1_0000, 64'h2000);
      expect_hit("R4 high top byte", 64'hFFFF_0000_0000_FFFF, 64'h1_1FFF, 1);
      expect_miss("R4 one past end", 64'hFFFF_0000_0001_0000);
   endtask

   task automatic t_priority;
      wr_trap(3, 64'h1000_0000, 64'h1_0000, 64'h5000_0000);
      expect_hit("R5 lower wins", 64'h1000_0010, 64'h8_0000_0010, 0);
      expect_hit("R5 only upper", 64'h1000_2000, 64'h5000_2000, 3);
      expect_hit("R2 range end", 64'h1000_FFFF, 64'h5000_FFFF, 3);
      expect_miss("R2 range past end", 64'h1001_0000);
   endtask

   task automatic t_bad_size;
      wr_trap(0, 64'h1000_0000, 64'h3000, 64'h9_0000_0000);
      expect_hit("R6 non-pow2 drops entry", 64'h1000_0010, 64'h5000_0010, 3);
      wr_trap(5, 64'h4000_0000, 64'h0, 64'h7000_0000);
      expect_miss("R6 zero size", 64'h4000_0000);
   endtask

   task automatic t_inv;
      // invalidate and request on the same edge: old table seen
      @(negedge clk);
      cfg_inv = 1'b1; cfg_idx = IW'(3);
      req_vld = 1'b1; req_addr = 64'h1000_2000;
      @(negedge clk);
      cfg_inv = 1'b0; req_vld = 1'b0;
      chk("R9 same-edge sees old", AW'(out_vld), AW'(1));
      chk("R9 same-edge addr", out_addr, 64'h5000_2000);
      expect_miss("R7 after invalidate", 64'h1000_2000);
      // invalidate wins over write in the same cycle
      @(negedge clk);
      cfg_inv = 1'b1; cfg_wr = 1'b1; cfg_idx = IW'(6);
      cfg_host_base = 64'h6000_0000; cfg_size = 64'h100; cfg_glob_base = 64'h100;
      @(negedge clk);
      cfg_inv = 1'b0; cfg_wr = 1'b0;
      expect_miss("R7 inv beats write", 64'h6000_0010);
   endtask

   task automatic t_last_and_hrst;
      wr_trap(7, 64'hA000_0000, 64'h10_0000, 64'h3_0000_0000);
      expect_hit("R2 last index", 64'hA00F_FFF0, 64'h3_000F_FFF0, 7);
      @(negedge clk);
      host_rst = 1'b1; cfg_wr = 1'b1; cfg_idx = IW'(2);
      cfg_host_base = 64'hB000_0000; cfg_size = 64'h1000; cfg_glob_base = 64'h0;
      @(negedge clk);
      host_rst = 1'b0; cfg_wr = 1'b0;
      expect_miss("R8 trap7 gone", 64'hA000_0000);
      expect_miss("R8 trap1 gone", 64'hFFFF_0000_0000_0000);
      expect_miss("R8 write blocked", 64'hB000_0000);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_wide();
      t_priority();
      t_bad_size();
      t_inv();
      t_last_and_hrst();
      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 5000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule